// File: doc/BRIEF.md
# Multi-Channel Debounced Interrupt Controller

This block watches up to eight asynchronous external input lines and turns each one into a clean, debounced level. Each line first passes through a two-flop synchronizer. A per-channel counter then counts millisecond ticks while the synchronized input differs from the accepted level. The new level is taken only after it has been held through the full programmed window. Any return to the accepted level inside the window clears the counter. The millisecond tick is produced by counting rising edges of a slow clock input, which is sampled in the system clock domain. `PRESCALE` edges make one tick.

Each channel can raise an interrupt once per arming. A channel armed by software sets its status bit on the first tick at which it is enabled and its accepted level equals its selected polarity. It then disarms itself. A write-1-to-clear removes status without re-arming. One interrupt output is the OR of the status bits left unmasked. The prescaler is held in reset, and `cnt_active` (meant to drive a clock gate) stays low, whenever no enabled channel is either mismatched or armed. The lines are input-only.

The register port is a plain single-cycle write strobe with a combinational read mux. It carries configuration, not a data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `dbnc_irq_top`

## Requirements
- R1: After reset all channels are disabled, polarity is 0, mask is 0, armed is 0, status is 0, the accepted level is 0, every debounce limit reads 1, and `irq` and `cnt_active` are 0.
- R2: A tick is one pulse per `PRESCALE` slow-clock rising edges. An enabled channel whose synchronized input has differed from its accepted level for `limit`+1 consecutive ticks adopts the input as its new accepted level.
- R3: An input held at a new level for less than `limit` tick periods never changes the accepted level. With `limit`=1, a pulse shorter than one tick is always ignored.
- R4: A return to the accepted level at any time inside the window restarts that channel's count from zero.
- R5: The per-channel limit register for channel c is at address 8+c. A written value of 0 reads back as 1, and a value above `MAX_MS` (4000) reads back as `MAX_MS`.
- R6: Writing 1s to address 2 arms those channels. An armed, enabled channel whose accepted level equals its polarity bit (address 1, 1 = high) sets its status bit at a tick and becomes disarmed. An armed channel whose level does not match stays armed and does not fire.
- R7: Writing 1s to address 6 clears those status bits. Clearing does not re-arm, so no second status is raised without a new arm write.
- R8: `irq` is high exactly when some status bit (read at address 4) is set and its mask bit (address 3, 1 = pass) is set. Address 5 reads status AND mask.
- R9: A channel whose enable bit (address 0) is 0 keeps its accepted level and never sets status.
- R10: `cnt_active` is 0, and the prescaler stays at phase 0, when no enabled channel is mismatched or armed. It is 1 while an enabled channel is counting.
- R11: The accepted levels of all channels read at address 7, bit c for channel c. Reads of addresses 0–7 return the channel bits at positions 0..N_CH-1 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow reference clock, sampled as data |
| ext_in | input | N_CH | Raw asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| irq | output | 1 | Combined masked interrupt |
| cnt_active | output | 1 | Counting-logic enable for a clock gate |

## Verification
The hardest cases to reach are the exact edges of the debounce window, because the tick phase is not visible at the ports and restarts whenever the gate closes. The bench does not predict exact cycles. It uses the fact that ticks are exactly 8 system cycles apart once running. A pulse of 8·limit−1 cycles can span at most `limit` ticks and must be ignored. A hold of 8·(limit+2)+4 cycles must be accepted whatever the phase. The sweep runs these cases, plus a split pulse for the restart case, on every channel with limits 1 to 4.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam logic [3:0] A_EN    = 4'd0;
  localparam logic [3:0] A_POL   = 4'd1;
  localparam logic [3:0] A_ARM   = 4'd2;
  localparam logic [3:0] A_MASK  = 4'd3;
  localparam logic [3:0] A_STAT  = 4'd4;
  localparam logic [3:0] A_MSTAT = 4'd5;
  localparam logic [3:0] A_CLR   = 4'd6;
  localparam logic [3:0] A_LVL   = 4'd7;
  localparam logic [3:0] A_LIM0  = 4'd8;

  // keep a written limit inside 1..max_v
  function automatic logic [15:0] clamp_lim(input logic [15:0] v, input logic [15:0] max_v);
    if (v == 16'd0) return 16'd1;
    else if (v > max_v) return max_v;
    else return v;
  endfunction
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end
  assign q = s2;
endmodule

// File: rtl/dbnc_tick.sv
module dbnc_tick #(
  parameter int PRESCALE = 32,
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_clk,
  input  logic          run,
  output logic          tick,
  output logic [PW-1:0] phase
);
  logic [2:0] sh;
  logic       rise;
  logic       last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], slow_clk};
  end

  assign rise = sh[1] & ~sh[2];
  assign last = (phase == PW'(PRESCALE - 1));
  assign tick = run & rise & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (!run) phase <= '0;
    else if (rise) phase <= last ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          din,
  input  logic [CW-1:0] limit,
  output logic          level,
  output logic          busy
);
  logic [CW-1:0] cnt;

  assign busy = en & (din != level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (!busy) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == limit) begin
        level <= din;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbnc_irq_top.sv
module dbnc_irq_top
  import dbnc_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int PRESCALE = 32,
  parameter int MAX_MS   = 4000,
  parameter int DW       = 16,
  localparam int CW      = $clog2(MAX_MS + 1),
  localparam int PW      = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_clk,
  input  logic [N_CH-1:0] ext_in,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [3:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            irq,
  output logic            cnt_active
);
  logic [N_CH-1:0] en_r, pol_r, mask_r, armed_r, stat_r;
  logic [N_CH-1:0] din_s, level, busy, fire, arm_wr, clr_wr;
  logic [N_CH*CW-1:0] lim_flat;
  logic            tick;
  logic [PW-1:0]   tick_phase;

  dbnc_sync #(.W(N_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_in), .q(din_s)
  );

  assign cnt_active = |(en_r & (busy | armed_r));

  dbnc_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .run(cnt_active),
    .tick(tick), .phase(tick_phase)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CW-1:0] lim_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim_q <= CW'(1);
      else if (wr_en && wr_addr == A_LIM0 + 4'(c))
        lim_q <= CW'(clamp_lim(16'(wr_data), 16'(MAX_MS)));
    end
    assign lim_flat[c*CW +: CW] = lim_q;

    dbnc_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .en(en_r[c]), .tick(tick), .din(din_s[c]),
      .limit(lim_q), .level(level[c]), .busy(busy[c])
    );
  end

  assign arm_wr = (wr_en && wr_addr == A_ARM) ? wr_data[N_CH-1:0] : '0;
  assign clr_wr = (wr_en && wr_addr == A_CLR) ? wr_data[N_CH-1:0] : '0;
  assign fire   = tick ? (armed_r & en_r & ~(level ^ pol_r)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r    <= '0;
      pol_r   <= '0;
      mask_r  <= '0;
      armed_r <= '0;
      stat_r  <= '0;
    end else begin
      if (wr_en && wr_addr == A_EN)   en_r   <= wr_data[N_CH-1:0];
      if (wr_en && wr_addr == A_POL)  pol_r  <= wr_data[N_CH-1:0];
      if (wr_en && wr_addr == A_MASK) mask_r <= wr_data[N_CH-1:0];
      armed_r <= (armed_r & ~fire) | arm_wr;
      stat_r  <= (stat_r & ~clr_wr) | fire;
    end
  end

  assign irq = |(stat_r & mask_r);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_EN:    rd_data = DW'(en_r);
      A_POL:   rd_data = DW'(pol_r);
      A_ARM:   rd_data = DW'(armed_r);
      A_MASK:  rd_data = DW'(mask_r);
      A_STAT:  rd_data = DW'(stat_r);
      A_MSTAT: rd_data = DW'(stat_r & mask_r);
      A_LVL:   rd_data = DW'(level);
      default: begin
        for (int c = 0; c < N_CH; c++)
          if (rd_addr == A_LIM0 + 4'(c)) rd_data = DW'(lim_flat[c*CW +: CW]);
      end
    endcase
  end
endmodule

// File: rtl/dbnc_irq_chk.sv
module dbnc_irq_chk
  import dbnc_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int MAX_MS = 4000,
  parameter int CW     = 12,
  parameter int PW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [PW-1:0]     tick_phase,
  input logic              cnt_active,
  input logic              irq,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic [N_CH-1:0]   en_r,
  input logic [N_CH-1:0]   mask_r,
  input logic [N_CH-1:0]   armed_r,
  input logic [N_CH-1:0]   stat_r,
  input logic [N_CH-1:0]   level,
  input logic [N_CH*CW-1:0] lim_flat
);
  AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_active) |-> (tick_phase == '0)); // R10

  AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> $past(tick)); // R2

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (((level ^ $past(level)) | (stat_r & ~$past(stat_r))) & ~$past(en_r)) == '0); // R9

  AST_FIRE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_r & ~$past(stat_r)) != '0) |->
      ($past(tick) && (((stat_r & ~$past(stat_r)) & ~$past(armed_r)) == '0))); // R6

  AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat_r & ~$past(stat_r)) != '0) && !$past(wr_en && wr_addr == A_ARM)) |->
      (((stat_r & ~$past(stat_r)) & armed_r) == '0)); // R7

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_r == '0) |-> !irq); // R8

  for (genvar c = 0; c < N_CH; c++) begin : g_lim
    AST_LIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_flat[c*CW +: CW] != '0) && (lim_flat[c*CW +: CW] <= CW'(MAX_MS))); // R5
  end
endmodule

bind dbnc_irq_top dbnc_irq_chk #(
  .N_CH(N_CH), .MAX_MS(MAX_MS), .CW(CW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tick_phase(tick_phase),
  .cnt_active(cnt_active), .irq(irq), .wr_en(wr_en), .wr_addr(wr_addr),
  .en_r(en_r), .mask_r(mask_r), .armed_r(armed_r), .stat_r(stat_r),
  .level(level), .lim_flat(lim_flat)
);

// File: tb/dbnc_irq_top_tb.sv
module dbnc_irq_top_tb;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int TP = 8; // system cycles per tick: PRESCALE 2 x slow period 4

  logic          clk = 0, rst_n = 0, slow_clk = 0;
  logic [N-1:0]  ext_in = '0;
  logic          wr_en = 0;
  logic [3:0]    wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic          irq, cnt_active;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;
  always #16 slow_clk = ~slow_clk;

  dbnc_irq_top #(.N_CH(N), .PRESCALE(2), .MAX_MS(4000), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .ext_in(ext_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .cnt_active(cnt_active)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a;
    #1 v = int'(rd_data);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, lim;
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R1 / R11 reset state through the register map
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), v); chk("R1 reg", v, 0);
    end
    for (int c = 0; c < N; c++) begin
      rd(4'(8 + c), v); chk("R1 limit", v, 1);
    end
    chk("R1 irq", int'(irq), 0);
    chk("R10 idle after reset", int'(cnt_active), 0);

    // R5 clamp
    wr(4'd8, 16'd0);    rd(4'd8, v); chk("R5 zero->1", v, 1);
    wr(4'd8, 16'd5000); rd(4'd8, v); chk("R5 clamp max", v, 4000);
    wr(4'd8, 16'd4000); rd(4'd8, v); chk("R5 max kept", v, 4000);

    for (int c = 0; c < N; c++) wr(4'(8 + c), 16'(c % 4 + 1));
    wr(4'd0, 16'hFF); wr(4'd1, 16'hFF); wr(4'd3, 16'hFF);
    rd(4'd0, v); chk("R11 enable readback", v, 255);

    // sweep all channels
    for (int c = 0; c < N; c++) begin
      lim = c % 4 + 1;
      ext_in[c] = 1; cyc(lim * TP - 1); ext_in[c] = 0; cyc(6);
      rd(4'd7, v); chk("R3 short pulse ignored", (v >> c) & 1, 0);
      ext_in[c] = 1; cyc(lim * TP - 1); ext_in[c] = 0; cyc(2);
      ext_in[c] = 1; cyc(lim * TP - 1); ext_in[c] = 0; cyc(6);
      rd(4'd7, v); chk("R4 restart on toggle", (v >> c) & 1, 0);
      ext_in[c] = 1; cyc(TP);
      chk("R10 active while counting", int'(cnt_active), 1);
      cyc((lim + 1) * TP + 4);
      rd(4'd7, v); chk("R2 accepted high", v, 1 << c);
      ext_in[c] = 0; cyc((lim + 2) * TP + 4);
      rd(4'd7, v); chk("R2 accepted low", v, 0);
      chk("R10 idle after settle", int'(cnt_active), 0);
    end
    rd(4'd4, v); chk("R6 no status without arm", v, 0);

    // R6 arm on matching level (channel 2 polarity low, level 0)
    wr(4'd1, 16'hFB); wr(4'd2, 16'h04); cyc(3 * TP);
    rd(4'd4, v); chk("R6 fired", v, 4);
    rd(4'd2, v); chk("R6 disarmed", v, 0);
    rd(4'd5, v); chk("R8 masked status", v, 4);
    chk("R8 irq high", int'(irq), 1);
    wr(4'd6, 16'h04); cyc(6 * TP);
    rd(4'd4, v); chk("R7 cleared", v, 0);
    rd(4'd2, v); chk("R7 not rearmed", v, 0);
    chk("R7 irq low", int'(irq), 0);

    // R8 masking
    wr(4'd3, 16'h00); wr(4'd2, 16'h04); cyc(3 * TP);
    rd(4'd4, v); chk("R8 raw status set", v, 4);
    rd(4'd5, v); chk("R8 masked out", v, 0);
    chk("R8 irq masked", int'(irq), 0);
    wr(4'd3, 16'h04); cyc(1);
    chk("R8 irq unmasked", int'(irq), 1);
    wr(4'd6, 16'hFF);

    // R6 armed but polarity mismatched until input rises
    wr(4'd1, 16'hFF); wr(4'd2, 16'h04); cyc(6 * TP);
    rd(4'd4, v); chk("R6 mismatch no fire", v, 0);
    rd(4'd2, v); chk("R6 stays armed", v, 4);
    ext_in[2] = 1; cyc(7 * TP);
    rd(4'd4, v); chk("R6 fires after level", v, 4);
    wr(4'd6, 16'hFF); ext_in[2] = 0; cyc(7 * TP);
    rd(4'd4, v); chk("R7 single trigger", v, 0);

    // R9 disabled channel
    wr(4'd0, 16'h00); wr(4'd1, 16'h00); wr(4'd2, 16'h20);
    ext_in[5] = 1; cyc(8 * TP);
    rd(4'd7, v); chk("R9 level held", v, 0);
    rd(4'd4, v); chk("R9 no status", v, 0);
    chk("R10 idle when disabled", int'(cnt_active), 0);
    ext_in[5] = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule